// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache Controller

This block is a small data cache that sits between a processor request port and a memory port that moves whole blocks. Each line holds four 32-bit words. Lines are placed by direct mapping: the line index is the block address modulo the number of lines, and the rest of the upper address bits form the tag. Stores update only the cache and mark the line dirty. A dirty line reaches memory only when a later miss evicts it. A store that misses first brings the block in and then writes into it (write-allocate).

The control path is a four-state machine:
- **Idle** waits for a request and latches it.
- **Compare Tag** looks up the indexed line. On a hit it completes the access, pulses `cpu_ready` and returns to Idle. On a miss it first records the old tag and rewrites the tag entry, then goes to Write-Back or Allocate.
- **Write-Back** sends the victim block to memory. It moves to Allocate when memory reports done.
- **Allocate** reads the new block and moves back to Compare Tag when memory reports done. The access then completes as a hit.

The tag, valid and dirty bits of a line form one entry in one storage array, so any change to one field rewrites the whole entry. The processor holds its request stable until it sees `cpu_ready`.

Top module: `wb_cache_ctrl`

## Requirements
- R1: Reset marks every line invalid and puts the machine in Idle, with `cpu_ready` and `mem_req_valid` low. A dirty line at the time of reset is dropped without a write-back.
- R2: In Idle, a high `cpu_req_valid` moves the machine to Compare Tag. `cpu_ready` is high only in a Compare Tag cycle that hits, for exactly one cycle, and the machine is in Idle in the next cycle.
- R3: A hit requires the indexed line to be valid and its stored tag to equal the request tag. A read hit returns on `cpu_rdata` the word selected by address bits [3:2]. Bits [1:0] have no effect on which word is returned.
- R4: A write hit replaces the selected word, rewrites the line's entry as valid, dirty, same tag, and makes no memory request.
- R5: A miss on a line that is invalid or clean issues exactly one memory read and no memory write.
- R6: A miss on a valid dirty line first issues one memory write and then the read. The write goes to the block address built from the old tag and the index. It carries the whole old line, with word w in bits [32w+31:32w].
- R7: While waiting for memory, `mem_req_valid`, `mem_req_write` and `mem_addr` stay unchanged until `mem_ready`. Write-Back then goes to Allocate. Allocate fills the line as valid and clean and returns to Compare Tag.
- R8: A write miss fetches the block, then writes the word into it and leaves the line dirty, so that a later eviction writes the stored value back.
- R9: `mem_addr` is block aligned (bits [3:0] zero). A memory read uses the request's tag and index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present, held until `cpu_ready` |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_write | output | 1 | 1 = block write, 0 = block read |
| mem_addr | output | 32 | Block-aligned memory byte address |
| mem_wblock | output | 128 | Block written to memory |
| mem_rblock | input | 128 | Block returned by memory, valid with `mem_ready` |
| mem_ready | input | 1 | Memory completes the current request |

## Verification
The sequence first makes a store hit dirty a line, then forces a conflicting read on the same index. A design that chose the eviction path from the wrong dirty bit would either lose the store or write back clean lines. The bench then checks the write-back address and block against the old tag. A design that overwrote the tag before capturing it would write the victim to the new block's address. Another case evicts a line that a write miss had filled, which shows whether write-allocate leaves the line dirty. Further cases read with nonzero byte offsets and reset with a dirty line present, where a wrong design would select the wrong word or write stale data back.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CMP   = 2'd1,
        ST_WB    = 2'd2,
        ST_ALLOC = 2'd3
    } wbc_state_e;
endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store #(
    parameter int LINES = 16,
    parameter int TAG_W = 24,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             we,
    input  logic             wr_valid,
    input  logic             wr_dirty,
    input  logic [TAG_W-1:0] wr_tag,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag
);
    // one entry = {valid, dirty, tag}; any field change rewrites all three
    localparam int ENT_W = TAG_W + 2;
    logic [ENT_W-1:0] entry_q [LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) entry_q[i] <= '0;
        end else if (we) begin
            entry_q[idx] <= {wr_valid, wr_dirty, wr_tag};
        end
    end

    assign {rd_valid, rd_dirty, rd_tag} = entry_q[idx];
endmodule

// File: rtl/wbc_data_store.sv
module wbc_data_store #(
    parameter int LINES  = 16,
    parameter int WORD_W = 32,
    parameter int WORDS  = 4,
    localparam int IDX_W  = $clog2(LINES),
    localparam int SEL_W  = $clog2(WORDS),
    localparam int LINE_W = WORD_W * WORDS
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic              word_we,
    input  logic [SEL_W-1:0]  word_sel,
    input  logic [WORD_W-1:0] word_data,
    input  logic              line_we,
    input  logic [LINE_W-1:0] line_data,
    output logic [LINE_W-1:0] rd_line
);
    // one storage lane per word position
    for (genvar w = 0; w < WORDS; w++) begin : g_lane
        logic [WORD_W-1:0] lane_q [LINES];

        always_ff @(posedge clk) begin
            if (line_we) begin
                lane_q[idx] <= line_data[w*WORD_W +: WORD_W];
            end else if (word_we && (word_sel == SEL_W'(w))) begin
                lane_q[idx] <= word_data;
            end
        end

        assign rd_line[w*WORD_W +: WORD_W] = lane_q[idx];
    end
endmodule

// File: rtl/wbc_fsm.sv
module wbc_fsm
    import wbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_req_valid,
    input  logic       req_write,
    input  logic       hit,
    input  logic       victim_dirty,
    input  logic       mem_ready,
    output wbc_state_e state_o,
    output logic       accept,
    output logic       cpu_ready,
    output logic       store_en,
    output logic       miss_upd,
    output logic       fill,
    output logic       mem_req_valid,
    output logic       mem_req_write
);
    wbc_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d       = state_q;
        accept        = 1'b0;
        cpu_ready     = 1'b0;
        store_en      = 1'b0;
        miss_upd      = 1'b0;
        fill          = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req_valid) begin
                    accept  = 1'b1;
                    state_d = ST_CMP;
                end
            end
            ST_CMP: begin
                if (hit) begin
                    cpu_ready = 1'b1;
                    store_en  = req_write;
                    state_d   = ST_IDLE;
                end else begin
                    miss_upd = 1'b1;
                    state_d  = victim_dirty ? ST_WB : ST_ALLOC;
                end
            end
            ST_WB: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                if (mem_ready) state_d = ST_ALLOC;
            end
            ST_ALLOC: begin
                mem_req_valid = 1'b1;
                if (mem_ready) begin
                    fill    = 1'b1;
                    state_d = ST_CMP;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/wb_cache_ctrl.sv
module wb_cache_ctrl
    import wbc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int WORDS  = 4,
    parameter int LINES  = 16,
    localparam int LINE_W  = WORD_W * WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wblock,
    input  logic [LINE_W-1:0] mem_rblock,
    input  logic              mem_ready
);
    localparam int OFF_W   = $clog2(WORD_W / 8);
    localparam int SEL_W   = $clog2(WORDS);
    localparam int IDX_W   = $clog2(LINES);
    localparam int BLK_OFF = OFF_W + SEL_W;
    localparam int TAG_W   = ADDR_W - IDX_W - BLK_OFF;
    localparam int RQA_W   = ADDR_W - OFF_W;

    // byte offset bits never select anything
    logic unused_byte_bits;
    assign unused_byte_bits = &{1'b0, cpu_req_addr[OFF_W-1:0]};

    wbc_state_e        state_q;
    logic              accept, store_en, miss_upd, fill;
    logic [RQA_W-1:0]  req_addr_q;
    logic              req_write_q;
    logic [WORD_W-1:0] req_wdata_q;
    logic [TAG_W-1:0]  vic_tag_q;

    logic [SEL_W-1:0]  req_sel;
    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    assign req_sel = req_addr_q[SEL_W-1:0];
    assign req_idx = req_addr_q[SEL_W +: IDX_W];
    assign req_tag = req_addr_q[RQA_W-1 -: TAG_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_addr_q  <= '0;
            req_write_q <= 1'b0;
            req_wdata_q <= '0;
            vic_tag_q   <= '0;
        end else begin
            if (accept) begin
                req_addr_q  <= cpu_req_addr[ADDR_W-1:OFF_W];
                req_write_q <= cpu_req_write;
                req_wdata_q <= cpu_wdata;
            end
            // keep the old tag before the entry is overwritten
            if (miss_upd) vic_tag_q <= ent_tag;
        end
    end

    logic             ent_valid, ent_dirty;
    logic [TAG_W-1:0] ent_tag;
    logic             tag_we, wr_valid, wr_dirty;
    logic             hit, victim_dirty;

    assign hit          = ent_valid && (ent_tag == req_tag);
    assign victim_dirty = ent_valid && ent_dirty;
    assign tag_we       = store_en || miss_upd || fill;
    assign wr_valid     = store_en || fill;
    assign wr_dirty     = store_en;

    wbc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (req_idx),
        .we       (tag_we),
        .wr_valid (wr_valid),
        .wr_dirty (wr_dirty),
        .wr_tag   (req_tag),
        .rd_valid (ent_valid),
        .rd_dirty (ent_dirty),
        .rd_tag   (ent_tag)
    );

    logic [LINE_W-1:0] rd_line;

    wbc_data_store #(.LINES(LINES), .WORD_W(WORD_W), .WORDS(WORDS)) u_data (
        .clk       (clk),
        .idx       (req_idx),
        .word_we   (store_en),
        .word_sel  (req_sel),
        .word_data (req_wdata_q),
        .line_we   (fill),
        .line_data (mem_rblock),
        .rd_line   (rd_line)
    );

    wbc_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_req_valid (cpu_req_valid),
        .req_write     (req_write_q),
        .hit           (hit),
        .victim_dirty  (victim_dirty),
        .mem_ready     (mem_ready),
        .state_o       (state_q),
        .accept        (accept),
        .cpu_ready     (cpu_ready),
        .store_en      (store_en),
        .miss_upd      (miss_upd),
        .fill          (fill),
        .mem_req_valid (mem_req_valid),
        .mem_req_write (mem_req_write)
    );

    assign cpu_rdata  = rd_line[req_sel*WORD_W +: WORD_W];
    assign mem_wblock = rd_line;
    assign mem_addr   = (state_q == ST_WB) ? {vic_tag_q, req_idx, {BLK_OFF{1'b0}}}
                                           : {req_tag,   req_idx, {BLK_OFF{1'b0}}};
endmodule

// File: rtl/wbc_checker.sv
module wbc_checker
    import wbc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input wbc_state_e        state,
    input logic              cpu_ready,
    input logic              mem_req_valid,
    input logic              mem_req_write,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr
);
    assert_ready_in_cmp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> state == ST_CMP);

    assert_ready_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready && state == ST_IDLE);

    assert_no_mem_on_lookup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_CMP) |-> !mem_req_valid);

    assert_mem_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_ready) |=>
            (mem_req_valid && $stable(mem_addr) && $stable(mem_req_write)));

    assert_wb_then_alloc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WB && mem_ready) |=> (state == ST_ALLOC && !mem_req_write));

    assert_alloc_then_cmp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ALLOC && mem_ready) |=> state == ST_CMP);
endmodule

bind wb_cache_ctrl wbc_checker #(.ADDR_W(ADDR_W)) u_wbc_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .state         (state_q),
    .cpu_ready     (cpu_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .mem_ready     (mem_ready),
    .mem_addr      (mem_addr)
);

// File: tb/wb_cache_ctrl_bench.sv
`timescale 1ns/1ps
module wb_cache_ctrl_bench;
    localparam int LAT = 3;
    localparam int NV  = 14;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_req_valid = 1'b0;
    logic         cpu_req_write = 1'b0;
    logic [31:0]  cpu_req_addr = '0;
    logic [31:0]  cpu_wdata = '0;
    logic [31:0]  cpu_rdata;
    logic         cpu_ready;
    logic         mem_req_valid, mem_req_write;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wblock;
    logic [127:0] mem_rblock = '0;
    logic         mem_ready = 1'b0;

    always #4 clk = ~clk;

    wb_cache_ctrl u_wb_cache_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
        .cpu_req_addr(cpu_req_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_addr(mem_addr), .mem_wblock(mem_wblock),
        .mem_rblock(mem_rblock), .mem_ready(mem_ready)
    );

    function automatic logic [31:0] init_word(input int blk, input int w);
        return 32'h1000_0000 + 32'(blk << 8) + 32'(w);
    endfunction

    // memory model: fixed latency, one-cycle ready pulse
    logic [127:0] mem_q [256];
    bit           mem_init = 1'b0;
    int           lat_cnt = 0;
    int           rd_count = 0, wb_count = 0;
    logic [31:0]  last_wb_addr = '0, last_rd_addr = '0;
    logic [127:0] last_wb_blk = '0;

    always @(negedge clk) begin
        if (!mem_init) begin
            for (int b = 0; b < 256; b++)
                for (int w = 0; w < 4; w++) mem_q[b][w*32 +: 32] = init_word(b, w);
            mem_init = 1'b1;
        end
        if (mem_ready) begin
            mem_ready = 1'b0;
            lat_cnt   = 0;
        end else if (mem_req_valid) begin
            if (lat_cnt == LAT) begin
                mem_ready = 1'b1;
                if (mem_req_write) begin
                    mem_q[mem_addr[11:4]] = mem_wblock;
                    wb_count++;
                    last_wb_addr = mem_addr;
                    last_wb_blk  = mem_wblock;
                end else begin
                    mem_rblock = mem_q[mem_addr[11:4]];
                    rd_count++;
                    last_rd_addr = mem_addr;
                end
            end else begin
                lat_cnt++;
            end
        end
    end

    int checks = 0, fails = 0;
    bit done = 1'b0;

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic access(input logic wr, input logic [31:0] addr,
                          input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_write = wr;
        cpu_req_addr  = addr;
        cpu_wdata     = wd;
        rd = 'x;
        for (int t = 0; t < 200; t++) begin
            @(negedge clk);
            if (cpu_ready) begin
                rd = cpu_rdata;
                break;
            end
        end
        cpu_req_valid = 1'b0;
        if (rd === 'x && !wr) check32("R2 ready timeout", 32'hX, 32'h1);
    endtask

    // {write, addr, wdata, expected rdata, expected reads, expected write-backs}
    localparam logic [100:0] VEC [NV] = '{
        {1'b0, 32'h000, 32'h0, 32'h1000_0000, 2'd1, 2'd0}, // R5 cold miss
        {1'b0, 32'h004, 32'h0, 32'h1000_0001, 2'd0, 2'd0}, // R3 hit word 1
        {1'b1, 32'h008, 32'hDEAD_BEEF, 32'h0, 2'd0, 2'd0}, // R4 write hit
        {1'b0, 32'h008, 32'h0, 32'hDEAD_BEEF, 2'd0, 2'd0}, // R4 readback
        {1'b0, 32'h100, 32'h0, 32'h1000_1000, 2'd1, 2'd1}, // R6 dirty conflict
        {1'b0, 32'h008, 32'h0, 32'hDEAD_BEEF, 2'd1, 2'd0}, // R6 data reached memory
        {1'b1, 32'h214, 32'h1234_5678, 32'h0, 2'd1, 2'd0}, // R8 write miss
        {1'b0, 32'h210, 32'h0, 32'h1000_2100, 2'd0, 2'd0}, // R8 rest of block fetched
        {1'b0, 32'h214, 32'h0, 32'h1234_5678, 2'd0, 2'd0}, // R8 stored word
        {1'b1, 32'h31C, 32'hCAFE_F00D, 32'h0, 2'd1, 2'd1}, // R8 allocated line dirty
        {1'b0, 32'h31C, 32'h0, 32'hCAFE_F00D, 2'd0, 2'd0}, // R3 word 3
        {1'b0, 32'h318, 32'h0, 32'h1000_3102, 2'd0, 2'd0}, // R3 word 2
        {1'b0, 32'h214, 32'h0, 32'h1234_5678, 2'd1, 2'd1}, // R6 evict write-miss line
        {1'b0, 32'h31C, 32'h0, 32'hCAFE_F00D, 2'd1, 2'd0}  // R7 fill leaves line clean
    };

    initial begin
        logic [31:0] rd;
        int r0, w0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset and right after it
        check32("R1 cpu_ready in reset", 32'(cpu_ready), 32'h0);
        check32("R1 mem_req_valid in reset", 32'(mem_req_valid), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check32("R1 cpu_ready after reset", 32'(cpu_ready), 32'h0);
        check32("R1 mem_req_valid after reset", 32'(mem_req_valid), 32'h0);

        for (int i = 0; i < NV; i++) begin
            r0 = rd_count;
            w0 = wb_count;
            access(VEC[i][100], VEC[i][99:68], VEC[i][67:36], rd);
            if (!VEC[i][100]) check32("R3 read data", rd, VEC[i][35:4]);
            check32("R5 memory reads", 32'(rd_count - r0), 32'(VEC[i][3:2]));
            check32("R6 memory write-backs", 32'(wb_count - w0), 32'(VEC[i][1:0]));
        end

        // R3: byte offset bits ignored
        r0 = rd_count;
        access(1'b0, 32'h00B, 32'h0, rd);
        check32("R3 byte offset ignored", rd, 32'hDEAD_BEEF);
        check32("R3 offset read is a hit", 32'(rd_count - r0), 32'h0);

        // R6/R9: write-back uses old tag, carries whole old line
        access(1'b1, 32'h054, 32'h55AA_55AA, rd);
        access(1'b0, 32'h457, 32'h0, rd);
        check32("R6 write-back address", last_wb_addr, 32'h050);
        check32("R6 write-back word 1", last_wb_blk[63:32], 32'h55AA_55AA);
        check32("R6 write-back word 0", last_wb_blk[31:0], init_word(5, 0));
        check32("R6 write-back word 3", last_wb_blk[127:96], init_word(5, 3));
        check32("R9 read address", last_rd_addr, 32'h450);
        check32("R9 read data", rd, init_word(8'h45, 1));

        // R1: reset drops a dirty line without writing it back
        access(1'b1, 32'h064, 32'h7777_0000, rd);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        r0 = rd_count;
        w0 = wb_count;
        access(1'b0, 32'h064, 32'h0, rd);
        check32("R1 reset invalidates lines", 32'(rd_count - r0), 32'h1);
        check32("R1 no write-back after reset", 32'(wb_count - w0), 32'h0);
        check32("R1 data from memory", rd, init_word(6, 1));

        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule